// File: doc/BRIEF.md
# Packed SIMD Saturating Add/Subtract Unit

This block adds or subtracts two 64-bit operands that each hold several packed integers. A lane-size input splits the 64 bits into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. Every lane is computed on its own. No carry or borrow ever passes from one lane into the next.

An arithmetic-mode input picks how a lane that goes out of range is handled. In wraparound mode the carry is dropped. In signed saturation the lane is clamped to its two's-complement limits. In unsigned saturation the lane is clamped to zero or to all ones. Pixel code gets clamped results in hardware, so it needs no range tests or branches in its inner loop.

Saturation is defined only for 8-bit and 16-bit lanes. If a saturating mode is requested with a 32-bit or 64-bit lane size, the unit raises a flag and returns the wraparound result. The result, its valid strobe and the flag are all registered, so the latency is one clock.

Top module: `simd_satadd`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid`, `illegal_mode` and `result` are cleared to zero at that edge.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge. Operands sampled with `in_valid` high appear on `result` exactly one clock later.
- R3: In wraparound mode with `sub_en`=0, each lane of `result` is (A+B) mod 2^w, where w is the lane width. A lane's carry out is dropped and never reaches the next lane.
- R4: In wraparound mode with `sub_en`=1, each lane is (A-B) mod 2^w. A borrow never passes between lanes.
- R5: Unsigned saturating add on 8-bit or 16-bit lanes forces any lane sum above 2^w-1 to 2^w-1. For example, bytes 200+175 give 255.
- R6: Unsigned saturating subtract on 8-bit or 16-bit lanes forces any lane difference below zero to 0.
- R7: Signed saturating add or subtract clamps 8-bit lanes to [-128, 127] and 16-bit lanes to [-32768, 32767].
- R8: A saturating mode (`arith_mode` 1 or 2) combined with a 32-bit or 64-bit lane size sets `illegal_mode` with the result. In that case the result is the wraparound value.
- R9: Encodings. `lane_sel` 0 selects 8-bit lanes, 1 selects 16-bit, 2 selects 32-bit and 3 selects 64-bit. `arith_mode` 0 and 3 select wraparound, 1 selects signed saturation and 2 selects unsigned saturation. `sub_en`=1 computes A-B.
- R10: When `in_valid` is low, `result` holds its last value and `illegal_mode` reads 0 on the next clock. `illegal_mode` is never 1 while `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| opa | input | 64 | Packed operand A |
| opb | input | 64 | Packed operand B |
| lane_sel | input | 2 | Lane size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit |
| arith_mode | input | 2 | 0/3 = wraparound, 1 = signed saturation, 2 = unsigned saturation |
| sub_en | input | 1 | 1 = A-B, 0 = A+B |
| out_valid | output | 1 | Result is valid (one clock after `in_valid`) |
| result | output | 64 | Packed lane results |
| illegal_mode | output | 1 | A saturating mode was requested on a 32-bit or 64-bit lane |

## Verification
The bench drives carries and borrows right at lane boundaries, such as 0xFF+0x01 and 0x00-0x01 in every lane and at every lane size. A design that lets a carry cross a lane would corrupt the neighbouring lane.

It also tests the clamp extremes:
- unsigned byte 200+175
- a zero floor on unsigned subtract
- 0x7F+1 and 0x80-1 in signed bytes
- 0x7FFF+1 in signed words

A design that wrapped, or clamped to the wrong limit, would show a bad lane value. The unit is also driven with a saturating mode on 32-bit and 64-bit lanes, with mode code 3, and with idle cycles. These cases catch a missing flag, a result that clamps when it must wrap, and a result that changes while idle.

// File: rtl/simd_pkg.sv
// Shared encodings for the packed add/subtract unit.
// Assumes lanes are whole multiples of an 8-bit segment.
package simd_pkg;
    localparam int SEG_W = 8;

    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_B16 = 2'd1,
        LANE_B32 = 2'd2,
        LANE_B64 = 2'd3
    } lane_e;

    typedef enum logic [1:0] {
        AM_WRAP  = 2'd0,
        AM_SSAT  = 2'd1,
        AM_USAT  = 2'd2,
        AM_WRAP3 = 2'd3
    } amode_e;
endpackage

// File: rtl/simd_mode_ctrl.sv
// Decodes the lane size into a segment mask and decides whether saturation
// is allowed. Assumes saturation is legal only for lane sizes below
// SAT_LIMIT (byte and word). An illegal request falls back to wraparound.
module simd_mode_ctrl #(
    parameter int NSEG      = 8,
    parameter int SAT_LIMIT = 2,
    localparam int SIDX_W   = $clog2(NSEG)
) (
    input  logic [1:0]        lane_sel,
    input  logic [1:0]        arith_mode,
    output logic [SIDX_W-1:0] lane_mask,
    output logic              sat_signed,
    output logic              sat_unsigned,
    output logic              illegal
);
    import simd_pkg::*;

    logic sat_req;
    logic sat_ok;

    // Low bits of a segment index that lie inside one lane.
    always_comb begin
        lane_mask = '0;
        for (int k = 0; k < SIDX_W; k++) begin
            if (k < int'(lane_sel)) lane_mask[k] = 1'b1;
        end
    end

    // Saturation request, legality check and the clamp mode that takes effect.
    always_comb begin
        sat_req      = (arith_mode == AM_SSAT) || (arith_mode == AM_USAT);
        sat_ok       = int'(lane_sel) < SAT_LIMIT;
        illegal      = sat_req && !sat_ok;
        sat_signed   = sat_ok && (arith_mode == AM_SSAT);
        sat_unsigned = sat_ok && (arith_mode == AM_USAT);
    end
endmodule

// File: rtl/simd_lane_adder.sv
// Segmented adder. Each 8-bit segment takes its carry-in from the segment
// below, except at a lane start, where the carry-in is the subtract bit.
// Subtraction is A + ~B + 1 per lane. Reports per-segment carry outs and
// the effective B sign bits for the clamp stage.
module simd_lane_adder #(
    parameter int DATA_W   = 64,
    localparam int NSEG    = DATA_W / simd_pkg::SEG_W,
    localparam int SIDX_W  = $clog2(NSEG)
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic [SIDX_W-1:0] lane_mask,
    output logic [DATA_W-1:0] sum,
    output logic [NSEG-1:0]   seg_cout,
    output logic [NSEG-1:0]   a_msb,
    output logic [NSEG-1:0]   b_msb
);
    localparam int SW = simd_pkg::SEG_W;

    logic [DATA_W-1:0] b_eff;
    logic [NSEG-1:0]   seg_cin;

    // Invert B for subtraction.
    always_comb b_eff = sub ? ~b : b;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        localparam logic [SIDX_W-1:0] SEG_IDX = SIDX_W'(s);
        logic lane_start;
        logic [SW:0] seg_sum;

        // A segment starts a lane when its index is aligned to the lane size.
        always_comb lane_start = (SEG_IDX & lane_mask) == '0;

        if (s == 0) begin : g_first
            // The lowest segment always starts a lane.
            always_comb seg_cin[s] = sub;
        end else begin : g_rest
            // Carry chain breaks at lane boundaries.
            always_comb seg_cin[s] = lane_start ? sub : seg_cout[s-1];
        end

        // One 8-bit slice of the chain.
        always_comb begin
            seg_sum = {1'b0, a[s*SW +: SW]} + {1'b0, b_eff[s*SW +: SW]}
                    + {{SW{1'b0}}, seg_cin[s]};
        end

        assign sum[s*SW +: SW] = seg_sum[SW-1:0];
        assign seg_cout[s]     = seg_sum[SW];
        assign a_msb[s]        = a[s*SW + SW - 1];
        assign b_msb[s]        = b_eff[s*SW + SW - 1];
    end
endmodule

// File: rtl/simd_sat_clamp.sv
// Per-lane overflow detection and clamping. Each segment looks up the flags
// of its lane's top segment and, if the lane overflowed, is replaced by its
// share of the clamp value. Assumes saturation is only enabled for lanes
// that the mode control declared legal.
module simd_sat_clamp #(
    parameter int DATA_W   = 64,
    localparam int NSEG    = DATA_W / simd_pkg::SEG_W,
    localparam int SIDX_W  = $clog2(NSEG)
) (
    input  logic [DATA_W-1:0] sum,
    input  logic [NSEG-1:0]   seg_cout,
    input  logic [NSEG-1:0]   a_msb,
    input  logic [NSEG-1:0]   b_msb,
    input  logic              sub,
    input  logic [SIDX_W-1:0] lane_mask,
    input  logic              sat_signed,
    input  logic              sat_unsigned,
    output logic [DATA_W-1:0] res
);
    localparam int SW = simd_pkg::SEG_W;

    logic [NSEG-1:0] s_ovf;
    logic [NSEG-1:0] u_ovf;

    // Overflow flags, valid at whichever segment is a lane's top.
    always_comb begin
        for (int s = 0; s < NSEG; s++) begin
            s_ovf[s] = (a_msb[s] == b_msb[s]) && (sum[s*SW + SW - 1] != a_msb[s]);
            u_ovf[s] = sub ? ~seg_cout[s] : seg_cout[s];
        end
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        localparam logic [SIDX_W-1:0] SEG_IDX = SIDX_W'(s);
        logic [SIDX_W-1:0] top;
        logic              force_sat;
        logic              positive;
        logic [SW-1:0]     fill;

        // Locate the lane top and decide whether this segment is clamped.
        always_comb begin
            top       = SEG_IDX | lane_mask;
            positive  = ~a_msb[top];
            force_sat = sat_signed ? s_ovf[top] : (sat_unsigned && u_ovf[top]);
        end

        // Clamp pattern for this segment's position within the lane.
        always_comb begin
            if (sat_signed) begin
                if (SEG_IDX == top) fill = positive ? {1'b0, {(SW-1){1'b1}}} : {1'b1, {(SW-1){1'b0}}};
                else                fill = positive ? {SW{1'b1}} : {SW{1'b0}};
            end else begin
                fill = sub ? {SW{1'b0}} : {SW{1'b1}};
            end
        end

        assign res[s*SW +: SW] = force_sat ? fill : sum[s*SW +: SW];
    end
endmodule

// File: rtl/simd_satadd.sv
// Top of the packed add/subtract unit. Combines mode decode, the segmented
// adder and the clamp stage, then registers result, valid and flag.
// Assumes a synchronous active-low reset and one operation per clock.
module simd_satadd #(
    parameter int DATA_W    = 64,
    parameter int SAT_LIMIT = 2,
    localparam int NSEG     = DATA_W / simd_pkg::SEG_W,
    localparam int SIDX_W   = $clog2(NSEG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [1:0]        lane_sel,
    input  logic [1:0]        arith_mode,
    input  logic              sub_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              illegal_mode
);
    logic [SIDX_W-1:0] lane_mask;
    logic              sat_signed;
    logic              sat_unsigned;
    logic              illegal;
    logic [DATA_W-1:0] sum;
    logic [NSEG-1:0]   seg_cout;
    logic [NSEG-1:0]   a_msb;
    logic [NSEG-1:0]   b_msb;
    logic [DATA_W-1:0] nxt_result;

    simd_mode_ctrl #(.NSEG(NSEG), .SAT_LIMIT(SAT_LIMIT)) u_mode (
        .lane_sel    (lane_sel),
        .arith_mode  (arith_mode),
        .lane_mask   (lane_mask),
        .sat_signed  (sat_signed),
        .sat_unsigned(sat_unsigned),
        .illegal     (illegal)
    );

    simd_lane_adder #(.DATA_W(DATA_W)) u_add (
        .a        (opa),
        .b        (opb),
        .sub      (sub_en),
        .lane_mask(lane_mask),
        .sum      (sum),
        .seg_cout (seg_cout),
        .a_msb    (a_msb),
        .b_msb    (b_msb)
    );

    simd_sat_clamp #(.DATA_W(DATA_W)) u_clamp (
        .sum         (sum),
        .seg_cout    (seg_cout),
        .a_msb       (a_msb),
        .b_msb       (b_msb),
        .sub         (sub_en),
        .lane_mask   (lane_mask),
        .sat_signed  (sat_signed),
        .sat_unsigned(sat_unsigned),
        .res         (nxt_result)
    );

    // Valid strobe and mode flag, one cycle behind the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            illegal_mode <= 1'b0;
        end else begin
            out_valid    <= in_valid;
            illegal_mode <= in_valid && illegal;
        end
    end

    // Result register, loaded only on a valid request.
    always_ff @(posedge clk) begin
        if (!rst_n)        result <= '0;
        else if (in_valid) result <= nxt_result;
    end

    // R2: the valid strobe follows the request by one clock.
    p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid));

    // R10: the flag is only raised with a valid result.
    p_flag_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_mode |-> out_valid);

    // R10: the result is frozen across idle cycles.
    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(result));

    // R8: a saturating request on a wide lane is flagged.
    p_wide_sat_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(lane_sel[1]) && ($past(arith_mode) == 2'd1 || $past(arith_mode) == 2'd2))
        |-> illegal_mode);

    // R3: a single 64-bit lane adds with plain wraparound.
    p_qword_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(lane_sel) == 2'd3 && !$past(sub_en))
        |-> result == $past(opa) + $past(opb));

    // R5: an unsigned saturating byte add never shrinks lane 0.
    p_usat_add_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(lane_sel) == 2'd0 && $past(arith_mode) == 2'd2 && !$past(sub_en))
        |-> result[7:0] >= $past(opa[7:0]));

    // R6: an unsigned saturating byte subtract never grows lane 0.
    p_usat_sub_ceiling_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(lane_sel) == 2'd0 && $past(arith_mode) == 2'd2 && $past(sub_en))
        |-> result[7:0] <= $past(opa[7:0]));

    // R7: the sum of two non-negative signed bytes stays non-negative.
    p_ssat_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(lane_sel) == 2'd0 && $past(arith_mode) == 2'd1 && !$past(sub_en)
         && !$past(opa[7]) && !$past(opb[7]))
        |-> !result[7]);
endmodule

// File: tb/simd_satadd_tb.sv
`timescale 1ns/1ps
// Bench for the packed add/subtract unit. A behavioural per-lane model
// tracks the expected outputs and is compared on every falling edge.
module simd_satadd_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic [1:0]  lane_sel = '0;
    logic [1:0]  arith_mode = '0;
    logic        sub_en = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal_mode;

    int          n_checks = 0;
    int          n_bad = 0;
    string       cur_tag = "R1";
    string       exp_tag = "R1";
    logic        exp_valid = 1'b0;
    logic        exp_ill = 1'b0;
    logic [63:0] exp_res = '0;
    bit          primed = 1'b0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    simd_satadd u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .opa         (opa),
        .opb         (opb),
        .lane_sel    (lane_sel),
        .arith_mode  (arith_mode),
        .sub_en      (sub_en),
        .out_valid   (out_valid),
        .result      (result),
        .illegal_mode(illegal_mode)
    );

    // Behavioural lane arithmetic, written from the requirements.
    function automatic void ref_op(input logic [63:0] a, input logic [63:0] b,
                                   input logic [1:0] ls, input logic [1:0] md,
                                   input logic sub, output logic [63:0] r,
                                   output logic ill);
        int          w;
        int          n;
        logic [63:0] mask;
        bit          sat_any;
        w       = 8 << ls;
        n       = 64 / w;
        mask    = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        sat_any = (md == 2'd1) || (md == 2'd2);
        ill     = sat_any && (ls >= 2'd2);
        r       = '0;
        for (int i = 0; i < n; i++) begin
            logic [63:0] ua, ub, lr;
            int x, sa, sb, lo, hi;
            ua = (a >> (i * w)) & mask;
            ub = (b >> (i * w)) & mask;
            if (!sat_any || ill) begin
                lr = (sub ? ua - ub : ua + ub) & mask;
            end else if (md == 2'd2) begin
                x = sub ? int'(ua) - int'(ub) : int'(ua) + int'(ub);
                if (x < 0) x = 0;
                if (x > int'(mask)) x = int'(mask);
                lr = 64'(x) & mask;
            end else begin
                hi = (1 << (w - 1)) - 1;
                lo = -(1 << (w - 1));
                sa = int'(ua); if (sa > hi) sa -= (1 << w);
                sb = int'(ub); if (sb > hi) sb -= (1 << w);
                x = sub ? sa - sb : sa + sb;
                if (x > hi) x = hi;
                if (x < lo) x = lo;
                lr = 64'(x) & mask;
            end
            r |= lr << (i * w);
        end
    endfunction

    // Model state advances at each rising edge from the sampled inputs.
    always @(posedge clk) begin
        logic [63:0] r;
        logic        il;
        primed <= 1'b1;
        if (!rst_n) begin
            exp_valid <= 1'b0;
            exp_ill   <= 1'b0;
            exp_res   <= '0;
            exp_tag   <= "R1";
        end else begin
            ref_op(opa, opb, lane_sel, arith_mode, sub_en, r, il);
            exp_valid <= in_valid;
            exp_ill   <= in_valid && il;
            if (in_valid) exp_res <= r;
            exp_tag   <= in_valid ? cur_tag : "R10";
        end
    end

    // Compare outputs against the model on every falling edge.
    always @(negedge clk) begin
        if (primed && !done) begin
            n_checks += 3;
            if (out_valid !== exp_valid) begin
                n_bad++;
                $display("FAIL %s out_valid act=%0b exp=%0b (R2)", exp_tag, out_valid, exp_valid);
            end
            if (result !== exp_res) begin
                n_bad++;
                $display("FAIL %s result act=%h exp=%h", exp_tag, result, exp_res);
            end
            if (illegal_mode !== exp_ill) begin
                n_bad++;
                $display("FAIL %s illegal_mode act=%0b exp=%0b", exp_tag, illegal_mode, exp_ill);
            end
        end
    end

    task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [1:0] ls,
                         input logic [1:0] md, input logic sub, input string tag);
        @(negedge clk);
        in_valid = 1'b1; opa = a; opb = b; lane_sel = ls; arith_mode = md; sub_en = sub;
        cur_tag = tag;
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        in_valid = 1'b0; opa = ~opa; opb = ~opb; arith_mode = 2'd2; lane_sel = 2'd3;
        cur_tag = tag;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state held for several clocks.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R3: byte wrap, 200+175=119, 0xFF+1 must not carry into the neighbour.
        drive(64'h01FF_80C8_7F00_FFC8, 64'h0101_80AF_0100_01AF, 2'd0, 2'd0, 1'b0, "R3");
        // R3: 16-bit and 32-bit wrap at boundaries.
        drive(64'h0000_FFFF_7FFF_FFFF, 64'h0000_0001_0001_0001, 2'd1, 2'd0, 1'b0, "R3");
        drive(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd2, 2'd0, 1'b0, "R3");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd3, 2'd0, 1'b0, "R3");
        // R4: subtraction borrows stay inside each lane.
        drive(64'h0, 64'h0101_0101_0101_0101, 2'd0, 2'd0, 1'b1, "R4");
        drive(64'h0001_0000_0001_0000, 64'h0000_0001_0000_0001, 2'd1, 2'd0, 1'b1, "R4");
        drive(64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, 2'd2, 2'd0, 1'b1, "R4");
        // R2: a gap in the valid stream.
        idle("R2");
        // R5: unsigned saturating add.
        drive(64'hC8C8_C8C8_0102_FFC8, 64'hAFAF_0000_0304_01AF, 2'd0, 2'd2, 1'b0, "R5");
        drive(64'hFFF0_8000_1234_0001, 64'h0020_8000_0001_FFFF, 2'd1, 2'd2, 1'b0, "R5");
        // R6: unsigned saturating subtract floors at zero.
        drive(64'h1020_3040_5060_7080, 64'h2020_2041_0061_FF7F, 2'd0, 2'd2, 1'b1, "R6");
        drive(64'h0010_8000_0000_FFFF, 64'h0020_7FFF_0001_FFFF, 2'd1, 2'd2, 1'b1, "R6");
        // R7: signed saturation for bytes and words.
        drive(64'h7F80_7F80_4040_C0C0, 64'h01FF_7F80_4040_C0C0, 2'd0, 2'd1, 1'b0, "R7");
        drive(64'h807F_0080_7F00_8000, 64'h01FF_0101_FF01_7F01, 2'd0, 2'd1, 1'b1, "R7");
        drive(64'h7FFF_8000_1000_FFFF, 64'h0001_FFFF_2000_0001, 2'd1, 2'd1, 1'b0, "R7");
        drive(64'h8000_7FFF_0000_0005, 64'h0001_FFFF_8000_0006, 2'd1, 2'd1, 1'b1, "R7");
        // R8: saturating mode on wide lanes is flagged and wraps.
        drive(64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0002, 2'd2, 2'd2, 1'b0, "R8");
        drive(64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 2'd3, 2'd1, 1'b0, "R8");
        drive(64'h0, 64'h1, 2'd2, 2'd1, 1'b1, "R8");
        // R9: mode code 3 behaves as wraparound.
        drive(64'hC8C8_C8C8_C8C8_C8C8, 64'hAFAF_AFAF_AFAF_AFAF, 2'd0, 2'd3, 1'b0, "R9");
        // R10: idle cycles hold the result and clear the flag.
        idle("R10");
        idle("R10");
        // R9: mixed stimulus over every encoding.
        for (int i = 0; i < 400; i++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (($urandom % 5) == 0) idle("R10");
            else drive(ra, rb, 2'($urandom), 2'($urandom), 1'($urandom), "R9");
        end
        idle("R10");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule